// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 bytes, with 17 address bits and an 8-bit data bus. The host makes one request at a time. It presents an address, a write flag and write data while `ready` is high. The controller then drives the RAM's two chip selects, one active-low and one active-high, along with the write-enable and output-enable strobes and the data bus drivers. It shapes each strobe so that every minimum interval of the selected speed grade is met.

The clock period in picoseconds and the speed grade are parameters. Grade 0 is the 55 ns part, grade 1 the 70 ns part and grade 2 the 85 ns part. Each nanosecond limit is turned into a cycle count when the design elaborates. The counts cover the cycle time, the access time, the write-enable pulse, the data setup and the bus turn-off time. When a read finishes, read data comes back to the host with a one-clock `rd_valid` pulse. Between requests both chip selects sit in their inactive state, so the RAM idles in standby.

Top module: `asram_ctl`

## Requirements
- R1: Every interval becomes a cycle count of ceil(ns*1000 / CLK_PS), with a minimum of 1. The nanosecond limits by grade (0/1/2) are: cycle and access time 55/70/85, write pulse 40/50/55, data setup 25/30/40, output turn-off 20/25/30.
- R2: Out of reset, and whenever no access is in progress, `ready` is 1, `mem_cs_n` is 1, `mem_cs` is 0, `mem_we_n` is 1, `mem_oe_n` is 1, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R3: A request is taken on a rising edge where `req` and `ready` are both 1. `ready` is 0 from the next cycle until the access, and any turnaround after it, is over. A `req` held high during that time starts no extra access.
- R4: A read keeps both selects active and `mem_oe_n` low for NR = max(cycle, access) cycles, with `mem_we_n` held high the whole time.
- R5: Read data is sampled from `mem_dq_in` at the end of the last read cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle, namely the cycle right after the read window.
- R6: After a read, `ready` stays low for a further NT = turn-off cycles, with the RAM deselected. Only then can the next request be taken.
- R7: A write keeps both selects active for NW = max(cycle, NWE+2) cycles. `mem_we_n` is high in the first of these cycles, then low for NWE = max(write pulse, data setup) cycles, then high again. `mem_oe_n` stays high throughout.
- R8: `mem_dq_oe` is high only during the first cycle of a write and the cycles where `mem_we_n` is low, and `mem_dq_out` carries the request's write data in those cycles. It is never high while `mem_oe_n` is low.
- R9: `mem_addr` does not change while the selects are active. It equals the address of the accepted request.
- R10: After a read, the controller starts no write, and does not drive the bus, until the turnaround of R6 is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can take a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write data |
| rd_data | output | 8 | Read data to host |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The assertions assume that `req`, `wr`, `addr` and `wdata` are free to change at any time and carry no meaning while `ready` is low. The bench exercises this by sometimes holding `req` high and shuffling the address through a whole access. The assertions also assume that the RAM model never drives `mem_dq_in` while output enable is high. The bench's RAM model returns garbage on the bus until the access time, counted in whole cycles, has elapsed, so that a read window that is too short shows up.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_TURN  = 2'd3
   } asram_st_e;

   // selectors for the nanosecond table
   localparam int LIM_CYCLE = 0;
   localparam int LIM_PULSE = 1;
   localparam int LIM_SETUP = 2;
   localparam int LIM_OFF   = 3;

   function automatic int lim_ns(input int grade, input int which);
      int v;
      case (which)
         LIM_CYCLE: v = (grade == 0) ? 55 : (grade == 1) ? 70 : 85;
         LIM_PULSE: v = (grade == 0) ? 40 : (grade == 1) ? 50 : 55;
         LIM_SETUP: v = (grade == 0) ? 25 : (grade == 1) ? 30 : 40;
         default:   v = (grade == 0) ? 20 : (grade == 1) ? 25 : 30;
      endcase
      return v;
   endfunction

   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int N_RD   = 11,
   parameter int N_WR   = 11,
   parameter int N_TURN = 4,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_wr,
   output asram_st_e     st,
   output logic [CW-1:0] cnt,
   output logic          rd_last
);

   localparam logic [CW-1:0] RD_END = CW'(N_RD - 1);
   localparam logic [CW-1:0] WR_END = CW'(N_WR - 1);
   localparam logic [CW-1:0] TN_END = CW'(N_TURN - 1);

   assign rd_last = (st == ST_READ) && (cnt == RD_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (start) st <= start_wr ? ST_WRITE : ST_READ;
            end
            ST_READ: begin
               if (cnt == RD_END) begin
                  st  <= ST_TURN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WRITE: begin
               if (cnt == WR_END) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == TN_END) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int AW   = 17,
   parameter int DW   = 8,
   parameter int N_WE = 8,
   parameter int CW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  asram_st_e     st,
   input  logic [CW-1:0] cnt,
   input  logic          rd_last,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_cs,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_out,
   input  logic [DW-1:0] mem_dq_in,
   output logic          mem_dq_oe,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);

   localparam logic [CW-1:0] WE_END = CW'(N_WE);

   logic in_acc;
   logic in_wr;

   assign in_acc     = (st == ST_READ) || (st == ST_WRITE);
   assign in_wr      = (st == ST_WRITE);
   assign mem_cs_n   = !in_acc;
   assign mem_cs     = in_acc;
   assign mem_oe_n   = (st != ST_READ);
   assign mem_we_n   = !(in_wr && (cnt != '0) && (cnt <= WE_END));
   assign mem_dq_oe  = in_wr && (cnt <= WE_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         rd_data    <= '0;
         rd_valid   <= 1'b0;
      end else begin
         if (start) begin
            mem_addr   <= addr;
            mem_dq_out <= wdata;
         end
         if (rd_last) rd_data <= mem_dq_in;
         rd_valid <= rd_last;
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int CLK_PS = 5000,
   parameter int GRADE  = 0,
   parameter int AW     = 17,
   parameter int DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   output logic          ready,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_cs,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_out,
   input  logic [DW-1:0] mem_dq_in,
   output logic          mem_dq_oe
);

   localparam int C_CYC  = ns_to_cyc(lim_ns(GRADE, LIM_CYCLE), CLK_PS);
   localparam int C_PW   = ns_to_cyc(lim_ns(GRADE, LIM_PULSE), CLK_PS);
   localparam int C_SU   = ns_to_cyc(lim_ns(GRADE, LIM_SETUP), CLK_PS);
   localparam int C_OFF  = ns_to_cyc(lim_ns(GRADE, LIM_OFF), CLK_PS);
   localparam int N_RD   = C_CYC;                     // access time equals cycle time
   localparam int N_WE   = imax(C_PW, C_SU);
   localparam int N_WR   = imax(C_CYC, N_WE + 2);
   localparam int N_TURN = C_OFF;
   localparam int N_MAX  = imax(imax(N_RD, N_WR), N_TURN);
   localparam int CW     = $clog2(N_MAX + 1);

   generate
      if (GRADE < 0 || GRADE > 2) begin : g_bad_grade
         $error("asram_ctl: GRADE must be 0, 1 or 2");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("asram_ctl: CLK_PS must be positive");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("asram_ctl: widths must be positive");
      end
   endgenerate

   asram_st_e     st;
   logic [CW-1:0] cnt;
   logic          rd_last;
   logic          start;

   assign ready = (st == ST_IDLE);
   assign start = req && ready;

   asram_seq #(
      .N_RD  (N_RD),
      .N_WR  (N_WR),
      .N_TURN(N_TURN),
      .CW    (CW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .start_wr(wr),
      .st      (st),
      .cnt     (cnt),
      .rd_last (rd_last)
   );

   asram_pins #(
      .AW  (AW),
      .DW  (DW),
      .N_WE(N_WE),
      .CW  (CW)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .addr      (addr),
      .wdata     (wdata),
      .st        (st),
      .cnt       (cnt),
      .rd_last   (rd_last),
      .mem_addr  (mem_addr),
      .mem_cs_n  (mem_cs_n),
      .mem_cs    (mem_cs),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .mem_dq_out(mem_dq_out),
      .mem_dq_in (mem_dq_in),
      .mem_dq_oe (mem_dq_oe),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
   import asram_pkg::*;
#(
   parameter int CLK_PS = 5000,
   parameter int GRADE  = 0,
   parameter int AW     = 17,
   parameter int DW     = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req,
   input logic          ready,
   input logic          rd_valid,
   input logic [AW-1:0] mem_addr,
   input logic          mem_cs_n,
   input logic          mem_cs,
   input logic          mem_we_n,
   input logic          mem_oe_n,
   input logic          mem_dq_oe
);

   localparam int WE_MIN = imax(ns_to_cyc(lim_ns(GRADE, LIM_PULSE), CLK_PS),
                                ns_to_cyc(lim_ns(GRADE, LIM_SETUP), CLK_PS));

   logic [15:0] we_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        we_run <= '0;
      else if (mem_we_n) we_run <= '0;
      else if (we_run != 16'hFFFF) we_run <= we_run + 1'b1;
   end

   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready); // R3

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R5

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R8

   AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_cs)); // R7

   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == 16'(WE_MIN))); // R7

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9

   AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n); // R4

endmodule

bind asram_ctl asram_ctl_chk #(
   .CLK_PS(CLK_PS),
   .GRADE (GRADE),
   .AW    (AW),
   .DW    (DW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .ready    (ready),
   .rd_valid (rd_valid),
   .mem_addr (mem_addr),
   .mem_cs_n (mem_cs_n),
   .mem_cs   (mem_cs),
   .mem_we_n (mem_we_n),
   .mem_oe_n (mem_oe_n),
   .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;

   localparam int CLK_PS = 5000;
   localparam int GRADE  = 0;
   localparam int AW     = 17;
   localparam int DW     = 8;

   // expected cycle counts from the R1 table (grade 0, 5 ns clock)
   function automatic int cdiv(input int ns);
      int c;
      c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_CYC = cdiv(55);
   localparam int E_AA  = cdiv(55);
   localparam int E_WE  = mx(cdiv(40), cdiv(25));
   localparam int E_OFF = cdiv(20);
   localparam int E_RD  = mx(E_CYC, E_AA);
   localparam int E_WR  = mx(E_CYC, E_WE + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          ready;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] ram_arr [int];
   logic [DW-1:0] ref_arr [int];
   int rd_run = 0;

   always #2.5 clk = ~clk;

   asram_ctl #(.CLK_PS(CLK_PS), .GRADE(GRADE), .AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr),
      .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
      .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   // RAM model: writes while WE is low, read data only after the access time
   always @(negedge clk) begin
      if (!mem_cs_n && mem_cs && !mem_we_n && mem_dq_oe)
         ram_arr[int'(mem_addr)] = mem_dq_out;
      if (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n) begin
         rd_run = rd_run + 1;
         if (rd_run >= E_AA)
            mem_dq_in <= ram_arr.exists(int'(mem_addr)) ? ram_arr[int'(mem_addr)] : 8'h00;
         else
            mem_dq_in <= 8'hEE;
      end else begin
         rd_run = 0;
         mem_dq_in <= 8'h5A;
      end
   end

   function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
      return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one access; hold_req keeps req high (with shifting inputs) during the access
   task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit hold_req);
      int sel_n, we_n_low, busy, vcnt, oe_low, drv_bad, dat_bad, addr_bad, first_we;
      int drv_n;
      logic [DW-1:0] got;
      logic [DW-1:0] exp_d;
      sel_n = 0; we_n_low = 0; busy = 0; vcnt = 0; oe_low = 0;
      drv_bad = 0; dat_bad = 0; addr_bad = 0; first_we = -1; drv_n = 0;
      got = '0;
      exp_d = ref_rd(a);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      while (!ready) begin
         busy++;
         if (hold_req) begin
            addr = AW'($urandom); wdata = DW'($urandom); wr = $urandom % 2;
         end else begin
            req = 1'b0;
         end
         if (!mem_cs_n && mem_cs) begin
            sel_n++;
            if (mem_addr !== a) addr_bad++;
         end
         if (!mem_we_n) begin
            we_n_low++;
            if (first_we < 0) first_we = sel_n;
         end
         if (!mem_oe_n) oe_low++;
         if (mem_dq_oe) begin
            drv_n++;
            if (!mem_oe_n || mem_cs_n) drv_bad++;
            if (mem_dq_out !== d) dat_bad++;
         end
         if (rd_valid) begin vcnt++; got = rd_data; end
         @(negedge clk);
      end
      req = 1'b0;
      if (rd_valid) begin vcnt++; got = rd_data; end
      chk(addr_bad == 0, "R9 address stable", addr_bad, 0);
      chk(drv_bad == 0, "R8 bus drive while output enabled", drv_bad, 0);
      if (w) begin
         ref_arr[int'(a)] = d;
         chk(sel_n == E_WR, "R7 write select cycles", sel_n, E_WR);
         chk(we_n_low == E_WE, "R7 write enable low cycles", we_n_low, E_WE);
         chk(first_we == 2, "R7 write enable starts after first cycle", first_we, 2);
         chk(oe_low == 0, "R7 output enable high in write", oe_low, 0);
         chk(drv_n == E_WE + 1, "R8 drive cycles", drv_n, E_WE + 1);
         chk(dat_bad == 0, "R8 write data on bus", dat_bad, 0);
         chk(busy == E_WR, "R3 busy cycles for write", busy, E_WR);
         chk(vcnt == 0, "R5 no valid on write", vcnt, 0);
      end else begin
         chk(sel_n == E_RD, "R4 read select cycles", sel_n, E_RD);
         chk(oe_low == E_RD, "R4 output enable low cycles", oe_low, E_RD);
         chk(we_n_low == 0, "R4 write enable high in read", we_n_low, 0);
         chk(busy == E_RD + E_OFF, "R6 read busy incl turnaround", busy, E_RD + E_OFF);
         chk(drv_n == 0, "R10 no drive during read or turnaround", drv_n, 0);
         chk(vcnt == 1, "R5 one valid pulse", vcnt, 1);
         chk(got == exp_d, "R5 read data", int'(got), int'(exp_d));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset/idle state
      chk(ready == 1'b1, "R2 ready after reset", ready, 1);
      chk(mem_cs_n == 1'b1 && mem_cs == 1'b0, "R2 deselected after reset",
          {mem_cs_n, mem_cs}, 2);
      chk(mem_we_n && mem_oe_n, "R2 strobes idle", {mem_we_n, mem_oe_n}, 3);
      chk(!mem_dq_oe && !rd_valid, "R2 no drive no valid", {mem_dq_oe, rd_valid}, 0);
      // R1 derived counts for grade 0 at 5 ns
      chk(E_RD == 11 && E_WE == 8 && E_OFF == 4 && E_WR == 11, "R1 cycle table",
          E_RD * 1000 + E_WE * 100 + E_OFF * 10 + E_WR, 11000 + 800 + 40 + 11);
      // directed corners
      do_op(1'b1, 17'h00000, 8'hA5, 1'b0);
      do_op(1'b1, 17'h1FFFF, 8'h3C, 1'b0);
      do_op(1'b0, 17'h00000, 8'h00, 1'b0);
      do_op(1'b1, 17'h00001, 8'hFF, 1'b1);   // R10: write right after a read
      do_op(1'b0, 17'h1FFFF, 8'h00, 1'b1);   // R3: req held during access
      do_op(1'b0, 17'h00001, 8'h00, 1'b0);
      do_op(1'b0, 17'h00001, 8'h00, 1'b0);   // back-to-back reads
      do_op(1'b1, 17'h00002, 8'h00, 1'b0);
      do_op(1'b1, 17'h00002, 8'h81, 1'b0);   // back-to-back writes
      do_op(1'b0, 17'h00002, 8'h00, 1'b0);
      // constrained random traffic on a small address pool
      for (int i = 0; i < 200; i++) begin
         logic [AW-1:0] ra;
         ra = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 32);
         do_op(($urandom % 100) < 45, ra, DW'($urandom), ($urandom % 4) == 0);
      end
      // R2 idle again after traffic
      repeat (2) @(negedge clk);
      chk(ready && mem_cs_n && !mem_cs && !mem_dq_oe, "R2 idle after traffic",
          {ready, mem_cs_n, mem_cs, mem_dq_oe}, 4'b1100);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule